// File: doc/BRIEF.md
# Asynchronous Byte-Wide RAM Port Cycle Decoder

This block sits behind the pins of a byte-wide static RAM port and turns their asynchronous control levels into clean, clocked transactions on a 512 by 8 internal array. The four control strobes (select, write, output and a nonvolatile qualifier) are oversampled. The address and input data are oversampled as well. A small cycle controller then works out whether the port is idle, reading or writing. It decides when the data bus may be driven, and it commits a write only once the write ends.

A write may be ended by the write strobe rising or by the select strobe rising. Whichever of the two rises first closes the write. The byte and the address present just before that edge are committed. If the write strobe was already low when the select strobe fell, the bus is never driven for the rest of that access. This holds even if the write strobe later returns high while the output strobe is low. If the address moves while a write is open, the block flags a protocol error and drops the write. The nonvolatile qualifier is only a gate: when it is low, no RAM access takes place.

Top module: `sram_port_decoder`

## Requirements
- R1: With port_sel_n high the block is deselected: port_drive stays 0 and no write is committed, whatever the other pins do.
- R2: port_sel_n=0, port_wr_n=1, port_out_n=0, port_nv_n=1 is a read. port_drive becomes 1 and port_dout shows the stored byte at port_addr. Both become valid at the third rising clock edge after the pins settle, and they hold while the pins are unchanged.
- R3: port_sel_n=0, port_wr_n=0, port_nv_n=1 is a write, regardless of port_out_n. port_drive is 0 while the write is open.
- R4: A write ended by port_wr_n rising commits the last sampled port_din to the last sampled port_addr.
- R5: A write ended by port_sel_n rising commits the same way.
- R6: If port_wr_n is low in the sample where port_sel_n falls, port_drive stays 0 until port_sel_n returns high. This holds even when port_wr_n later rises with port_out_n low.
- R7: An address change while a write is open sets proto_err and the write is not committed. proto_err stays 1 until the next write opens, which clears it.
- R8: port_nv_n low with port_sel_n low gives no access: no drive, and no write. A write that is open when port_nv_n falls is aborted without a commit.
- R9: A read with port_out_n high leaves port_drive at 0.
- R10: The array holds 512 independent bytes. Addresses 0 and 511 are both reachable and keep distinct values.
- R11: After reset, port_drive, proto_err and port_dout are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| port_sel_n | input | 1 | Asynchronous select strobe, active low |
| port_wr_n | input | 1 | Asynchronous write strobe, active low |
| port_out_n | input | 1 | Asynchronous output strobe, active low |
| port_nv_n | input | 1 | Nonvolatile qualifier; must be high for RAM access |
| port_addr | input | 9 | Asynchronous word address |
| port_din | input | 8 | Data bus, inbound half |
| port_dout | output | 8 | Data bus, outbound half |
| port_drive | output | 1 | Output enable for the data bus |
| proto_err | output | 1 | Address moved during an open write |

## Verification
The bench builds the block with its defaults: a 9-bit address, an 8-bit word and two synchroniser stages. With these values the full 512-entry array is in play, including the boundary addresses 0 and 511. Random writes mix endings by the write strobe and by the select strobe. They are interleaved with reads checked against a shadow array. Directed sequences cover the early-write suppression of the bus, an address change inside a write, and a qualifier drop inside a write.

// File: rtl/spd_pkg.sv
// Package spd_pkg
// Shared types for the byte-wide port decoder: the access kind that the
// sampled control strobes select, and the function that decodes it.
// Assumes all strobes are active low and already synchronised.
package spd_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,   // select strobe high
        ACC_READ  = 2'd1,   // read with output enabled
        ACC_WRITE = 2'd2,   // write strobe low, qualifier high
        ACC_NOP   = 2'd3    // selected but nothing to do
    } acc_e;

    // Decode the four sampled strobes into an access kind.
    function automatic acc_e decode_access(
        input logic sel_n,
        input logic wr_n,
        input logic out_n,
        input logic nv_n
    );
        acc_e k;
        if (sel_n)       k = ACC_IDLE;
        else if (!nv_n)  k = ACC_NOP;
        else if (!wr_n)  k = ACC_WRITE;
        else if (!out_n) k = ACC_READ;
        else             k = ACC_NOP;
        return k;
    endfunction

endpackage

// File: rtl/spd_sync.sv
// Module spd_sync
// Multi-stage synchroniser for a group of asynchronous pins. Each bit passes
// through STAGES flops. The whole group is sampled in lockstep, so the
// relative order of pin changes is kept when they are a full clock apart.
// Assumes the pins change no faster than once per few clocks.
module spd_sync #(
    parameter int            W       = 1,
    parameter int            STAGES  = 2,
    parameter logic [W-1:0]  RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage samples the raw pins.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= d;
                end
            end else begin : g_next
                // Later stages resample the previous stage.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= RST_VAL;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/spd_array.sv
// Module spd_array
// The word store: one synchronous write port and a registered read port.
// The read register loads only while a read is requested, so the output
// holds its last value otherwise. Contents are not cleared by reset.
module spd_array #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Commit one word when the controller requests it.
    always_ff @(posedge clk) begin
        if (wr_en) store[wr_addr] <= wr_data;
    end

    // Register the addressed word while a read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= store[rd_addr];
    end

endmodule

// File: rtl/spd_cycle_ctrl.sv
// Module spd_cycle_ctrl
// Tracks read and write cycles from the synchronised strobes. A write opens
// when the decode shows a write. Address and data are held every open
// cycle, and the write is committed on the cycle it closes. It is not
// committed if the address moved or the qualifier dropped. Bus drive is
// registered and blocked for an access whose select fell with write low.
module spd_cycle_ctrl
    import spd_pkg::*;
#(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel_n,
    input  logic          wr_n,
    input  logic          out_n,
    input  logic          nv_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] din,
    output logic          mem_we,
    output logic [AW-1:0] mem_waddr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_re,
    output logic          drive,
    output logic          err
);

    acc_e          kind;
    logic          wr_act;
    logic          wr_open;
    logic          wr_start;
    logic          wr_close;
    logic          nv_abort;
    logic          sel_prev;
    logic          quiet;
    logic [AW-1:0] hold_addr;
    logic [DW-1:0] hold_data;

    // Classify the current sample and derive the write-cycle events.
    always_comb begin
        kind     = decode_access(sel_n, wr_n, out_n, nv_n);
        wr_act   = (kind == ACC_WRITE);
        wr_start = wr_act && !wr_open;
        wr_close = wr_open && !wr_act;
        nv_abort = !sel_n && !wr_n && !nv_n;
    end

    // Track whether a write is open and hold its address and data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_open   <= 1'b0;
            hold_addr <= '0;
            hold_data <= '0;
        end else begin
            wr_open <= wr_act;
            if (wr_act) begin
                hold_addr <= addr;
                hold_data <= din;
            end
        end
    end

    // Flag an address change inside an open write; clear on the next write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   err <= 1'b0;
        else if (wr_start)                            err <= 1'b0;
        else if (wr_act && wr_open && addr != hold_addr) err <= 1'b1;
    end

    // Remember the previous select level to find its falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_prev <= 1'b1;
        else        sel_prev <= sel_n;
    end

    // Block drive for an access that began with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)                   quiet <= 1'b0;
        else if (sel_n)               quiet <= 1'b0;
        else if (sel_prev && !wr_n)   quiet <= 1'b1;
    end

    // Register the bus drive for the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) drive <= 1'b0;
        else        drive <= (kind == ACC_READ) && !quiet;
    end

    // Commit on close unless the write was flagged or aborted.
    always_comb begin
        mem_we    = wr_close && !err && !nv_abort;
        mem_waddr = hold_addr;
        mem_wdata = hold_data;
        mem_re    = (kind == ACC_READ);
    end

endmodule

// File: rtl/sram_port_decoder.sv
// Module sram_port_decoder
// Top of the byte-wide port decoder. It synchronises the strobes, address
// and data, decodes cycles in spd_cycle_ctrl, and keeps the words in
// spd_array. The data bus is split into an inbound half, an outbound half
// and a drive enable; the pad ring joins them.
module sram_port_decoder #(
    parameter int ADDR_W      = 9,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              port_sel_n,
    input  logic              port_wr_n,
    input  logic              port_out_n,
    input  logic              port_nv_n,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [DATA_W-1:0] port_din,
    output logic [DATA_W-1:0] port_dout,
    output logic              port_drive,
    output logic              proto_err
);

    localparam int CTL_W = 4;
    localparam int BUS_W = ADDR_W + DATA_W;

    logic [CTL_W-1:0]  ctl_s;
    logic [BUS_W-1:0]  bus_s;
    logic              sel_s;
    logic              wr_s;
    logic              out_s;
    logic              nv_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] din_s;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [DATA_W-1:0] mem_wdata;
    logic              mem_re;

    spd_sync #(
        .W       (CTL_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({CTL_W{1'b1}})
    ) ctl_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({port_sel_n, port_wr_n, port_out_n, port_nv_n}),
        .q     (ctl_s)
    );

    spd_sync #(
        .W       (BUS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL ({BUS_W{1'b0}})
    ) bus_sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({port_addr, port_din}),
        .q     (bus_s)
    );

    assign {sel_s, wr_s, out_s, nv_s} = ctl_s;
    assign {addr_s, din_s}            = bus_s;

    spd_cycle_ctrl #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_n     (sel_s),
        .wr_n      (wr_s),
        .out_n     (out_s),
        .nv_n      (nv_s),
        .addr      (addr_s),
        .din       (din_s),
        .mem_we    (mem_we),
        .mem_waddr (mem_waddr),
        .mem_wdata (mem_wdata),
        .mem_re    (mem_re),
        .drive     (port_drive),
        .err       (proto_err)
    );

    spd_array #(
        .AW (ADDR_W),
        .DW (DATA_W)
    ) array_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mem_we),
        .wr_addr (mem_waddr),
        .wr_data (mem_wdata),
        .rd_en   (mem_re),
        .rd_addr (addr_s),
        .rd_data (port_dout)
    );

endmodule

// File: rtl/spd_checker.sv
// Module spd_checker
// Temporal checks on the decoder, attached to every instance of the top
// module through the bind below. It observes the synchronised strobes, the
// commit strobe and the outputs.
module spd_checker (
    input logic clk,
    input logic rst_n,
    input logic sel_s,
    input logic wr_s,
    input logic out_s,
    input logic nv_s,
    input logic mem_we,
    input logic drive,
    input logic err
);

    logic early_wr;

    // Independent record of an access that opened with the write strobe low.
    always_ff @(posedge clk) begin
        if (!rst_n)                          early_wr <= 1'b0;
        else if (sel_s)                      early_wr <= 1'b0;
        else if ($fell(sel_s) && !wr_s)      early_wr <= 1'b1;
    end

    // R1
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_s |=> !drive);

    // R1
    deselect_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_s && $past(sel_s)) |-> !mem_we);

    // R2
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> $past(!sel_s && wr_s && !out_s && nv_s));

    // R3
    write_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_s && !wr_s) |=> !drive);

    // R4
    commit_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(!sel_s && !wr_s && nv_s));

    // R6
    early_write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (early_wr && !sel_s) |=> !drive);

    // R7
    err_blocks_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !err);

endmodule

bind sram_port_decoder spd_checker chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel_s  (sel_s),
    .wr_s   (wr_s),
    .out_s  (out_s),
    .nv_s   (nv_s),
    .mem_we (mem_we),
    .drive  (port_drive),
    .err    (proto_err)
);

// File: tb/sram_port_decoder_tb_top.sv
// Bench for sram_port_decoder: directed corner cases plus seeded random
// reads and writes, checked against a shadow array.
module sram_port_decoder_tb_top;

    localparam int AW    = 9;
    localparam int DW    = 8;
    localparam int DEPTH = 1 << AW;
    localparam int SETTLE = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          wr_n = 1'b1;
    logic          out_n = 1'b1;
    logic          nv_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          drive;
    logic          perr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [DW-1:0] shadow [DEPTH];
    bit            known  [DEPTH];

    always #2 clk = ~clk;

    sram_port_decoder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .port_sel_n (sel_n),
        .port_wr_n  (wr_n),
        .port_out_n (out_n),
        .port_nv_n  (nv_n),
        .port_addr  (addr),
        .port_din   (din),
        .port_dout  (dout),
        .port_drive (drive),
        .proto_err  (perr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic pins(input logic s, input logic w, input logic o, input logic n);
        sel_n = s; wr_n = w; out_n = o; nv_n = n;
        settle();
    endtask

    // Expected read result from the shadow array.
    function automatic logic [DW-1:0] expect_byte(input logic [AW-1:0] a);
        return shadow[a];
    endfunction

    // Write strobe ends the write (R4).
    task automatic write_by_wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; din = d;
        pins(0, 1, 1, 1);
        pins(0, 0, 1, 1);
        pins(0, 1, 1, 1);
        pins(1, 1, 1, 1);
        shadow[a] = d; known[a] = 1'b1;
    endtask

    // Select strobe ends the write (R5).
    task automatic write_by_sel(input logic [AW-1:0] a, input logic [DW-1:0] d);
        addr = a; din = d;
        pins(1, 0, 0, 1);
        pins(0, 0, 0, 1);
        pins(1, 0, 0, 1);
        pins(1, 1, 1, 1);
        shadow[a] = d; known[a] = 1'b1;
    endtask

    task automatic read_chk(input logic [AW-1:0] a, input string req);
        addr = a;
        pins(0, 1, 0, 1);
        chk(drive === 1'b1, req, drive, 1);
        chk(dout === expect_byte(a), req, dout, expect_byte(a));
        pins(1, 1, 1, 1);
    endtask

    initial begin
        void'($urandom(32'h0000_51ED));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(drive === 1'b0, "R11", drive, 0);
        chk(perr === 1'b0, "R11", perr, 0);
        chk(dout === '0, "R11", dout, 0);
        rst_n = 1'b1;
        settle();

        // R10: both ends of the array
        write_by_wr(9'd0, 8'h3C);
        write_by_sel(9'd511, 8'hC3);
        read_chk(9'd0, "R10");
        read_chk(9'd511, "R10");

        // R2: read holds while pins are steady
        addr = 9'd511;
        pins(0, 1, 0, 1);
        settle();
        chk(dout === 8'hC3 && drive === 1'b1, "R2", dout, 8'hC3);
        pins(1, 1, 1, 1);

        // R1: deselected, write strobe toggled, nothing changes
        addr = 9'd0; din = 8'hFF;
        pins(1, 0, 0, 1);
        chk(drive === 1'b0, "R1", drive, 0);
        pins(1, 1, 0, 1);
        read_chk(9'd0, "R1");

        // R9: read with the output strobe high
        addr = 9'd0;
        pins(0, 1, 1, 1);
        chk(drive === 1'b0, "R9", drive, 0);
        pins(1, 1, 1, 1);

        // R3 and R6: select falls with the write strobe already low
        addr = 9'd77; din = 8'h5A;
        pins(1, 0, 0, 1);
        pins(0, 0, 0, 1);
        chk(drive === 1'b0, "R3", drive, 0);
        pins(0, 1, 0, 1);
        chk(drive === 1'b0, "R6", drive, 0);
        pins(1, 1, 1, 1);
        shadow[77] = 8'h5A; known[77] = 1'b1;
        read_chk(9'd77, "R4");

        // R7: address moves inside a write
        write_by_wr(9'd10, 8'h11);
        write_by_wr(9'd11, 8'h22);
        addr = 9'd10; din = 8'h99;
        pins(0, 1, 1, 1);
        pins(0, 0, 1, 1);
        addr = 9'd11;
        settle();
        chk(perr === 1'b1, "R7", perr, 1);
        pins(0, 1, 1, 1);
        pins(1, 1, 1, 1);
        chk(perr === 1'b1, "R7", perr, 1);
        read_chk(9'd10, "R7");
        read_chk(9'd11, "R7");
        addr = 9'd12; din = 8'h44;
        pins(0, 1, 1, 1);
        pins(0, 0, 1, 1);
        chk(perr === 1'b0, "R7", perr, 0);
        pins(0, 1, 1, 1);
        pins(1, 1, 1, 1);
        shadow[12] = 8'h44; known[12] = 1'b1;
        read_chk(9'd12, "R7");

        // R8: qualifier low blocks reads and aborts an open write
        addr = 9'd12;
        pins(0, 1, 0, 0);
        chk(drive === 1'b0, "R8", drive, 0);
        pins(1, 1, 1, 1);
        addr = 9'd12; din = 8'hEE;
        pins(0, 1, 1, 1);
        pins(0, 0, 1, 1);
        pins(0, 0, 1, 0);
        pins(0, 1, 1, 0);
        pins(1, 1, 1, 1);
        read_chk(9'd12, "R8");

        // Random mix of writes (R4, R5) and reads (R2)
        for (int i = 0; i < 300; i++) begin
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            a = AW'($urandom_range(DEPTH - 1));
            d = DW'($urandom);
            if (($urandom_range(2) != 0) || !known[a]) begin
                if ($urandom_range(1) == 0) write_by_wr(a, d);
                else                        write_by_sel(a, d);
            end else begin
                read_chk(a, "R2");
            end
        end
        // Final read-back of the boundary addresses after the random phase.
        read_chk(9'd0, "R5");
        read_chk(9'd511, "R5");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run is a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule